// File: doc/BRIEF.md
# Set/Clear Alias Control Register

This block holds one 64-bit control word behind a small memory-mapped request port. The word is reachable at three consecutive 8-byte slots. The first slot is an ordinary read/write location. The second folds the write data into the word with a bitwise AND, so software can clear chosen bits in one store. The third folds it in with a bitwise OR, so software can set chosen bits in one store. Neither alias needs a read-modify-write sequence. Only the upper `KEEP_BITS` bits of the word are held. Every lower bit is forced to zero on each update. The most significant held bit leaves the block as a level-sensitive interrupt.

Every request is accepted in the cycle it is presented. The request side therefore has no ready signal and never applies back-pressure, and a new request may follow in every cycle. Exactly one response is returned for each request, one cycle later. The response has no ready signal either, so the consumer must take it in the cycle it appears. A response reports the read data, a size/alignment error, or an access to an index that is not implemented. Data words are big-endian: bit 63 is the most significant bit and is carried on `req_wdata[63]` / `resp_rdata[63]`.

Top module: `alias_ctl_reg`

## Requirements
- R1: An accepted write at byte address `BASE_INDEX*8` (the direct slot) replaces the stored word with the write data, after masking.
- R2: An accepted write at byte address `(BASE_INDEX+1)*8` stores the current word ANDed with the write data.
- R3: An accepted write at byte address `(BASE_INDEX+2)*8` stores the current word ORed with the write data.
- R4: On every update, bits 63..(64-`KEEP_BITS`) are kept and all lower bits are stored as zero. With the default `KEEP_BITS`=16, bits 47..0 always read zero.
- R5: `irq_out` equals bit 63 of the stored word. It changes on the same clock edge as the write that changes that bit, and this holds for writes through the direct slot and through both aliases.
- R6: A legal read of the direct slot returns the stored word on `resp_rdata` in the next cycle. A read of any other index, the two aliases included, returns zero.
- R7: A legal access reports `resp_unimpl`=1 in its response cycle in two cases: a write to an index outside the three slots, or a read of any index other than the direct slot. Such an access leaves the stored word unchanged.
- R8: An access whose `req_size` is not 8, or whose `req_addr[2:0]` is not 0, is ignored. Its response has `resp_err`=1, `resp_unimpl`=0 and `resp_rdata`=0.
- R9: After reset the stored word is zero, `irq_out` is 0 and `resp_valid` is 0.
- R10: Every cycle with `req_valid`=1 produces exactly one cycle of `resp_valid`=1 on the next cycle. Back-to-back requests are served in order, and a read that directly follows a write sees the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle; always accepted |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_size | input | SIZE_W | Access size in bytes; only 8 is legal |
| req_wdata | input | 64 | Write data, bit 63 most significant |
| resp_valid | output | 1 | Response strobe, one cycle after the request |
| resp_rdata | output | 64 | Read data; zero for writes, errors and non-direct reads |
| resp_err | output | 1 | Size or alignment error on the request |
| resp_unimpl | output | 1 | Access to an index not implemented for that direction |
| irq_out | output | 1 | Interrupt level, equal to stored bit 63 |

## Verification
Several behaviours are checked by the assertions on every cycle:
- one response per request, a cycle later;
- the error and unimplemented flags are exclusive;
- the masked low bits read as zero;
- a direct read's top bit agrees with the interrupt level;
- rejected or undecoded writes leave the interrupt level untouched.

Only the bench's scenarios can show the arithmetic of the register. It sweeps indices around the three slots in both directions, sets and clears every bit position through the aliases, and sweeps every illegal size and misalignment. It compares each response with a model word kept in the bench. It also drives back-to-back write-then-read traffic.

// File: rtl/alias_reg_pkg.sv
package alias_reg_pkg;

  // Which slot a legal access has hit.
  typedef enum logic [1:0] {
    SLOT_DIRECT = 2'd0,
    SLOT_AND    = 2'd1,
    SLOT_OR     = 2'd2,
    SLOT_NONE   = 2'd3
  } slot_e;

endpackage

// File: rtl/ar_decode.sv
module ar_decode
  import alias_reg_pkg::*;
#(
  parameter int ADDR_W       = 24,
  parameter int SIZE_W       = 4,
  parameter int ACCESS_BYTES = 8,
  parameter int BASE_INDEX   = 'h4020
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [SIZE_W-1:0] size,
  output logic              legal,
  output slot_e             slot
);
  localparam int ALIGN_W = $clog2(ACCESS_BYTES);
  localparam int IDX_W   = ADDR_W - ALIGN_W;
  localparam logic [IDX_W-1:0] IDX_DIRECT = IDX_W'(BASE_INDEX);
  localparam logic [IDX_W-1:0] IDX_AND    = IDX_W'(BASE_INDEX + 1);
  localparam logic [IDX_W-1:0] IDX_OR     = IDX_W'(BASE_INDEX + 2);

  logic [IDX_W-1:0] idx;
  logic             size_ok;
  logic             align_ok;

  assign idx      = addr[ADDR_W-1:ALIGN_W];
  assign size_ok  = (size == SIZE_W'(ACCESS_BYTES));
  assign align_ok = (addr[ALIGN_W-1:0] == '0);
  assign legal    = size_ok && align_ok;

  always_comb begin
    if (idx == IDX_DIRECT)   slot = SLOT_DIRECT;
    else if (idx == IDX_AND) slot = SLOT_AND;
    else if (idx == IDX_OR)  slot = SLOT_OR;
    else                     slot = SLOT_NONE;
  end
endmodule

// File: rtl/ar_store.sv
module ar_store
  import alias_reg_pkg::*;
#(
  parameter int DATA_W    = 64,
  parameter int KEEP_BITS = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  slot_e             slot,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] word_q,
  output logic              irq
);
  localparam int DROP_BITS = DATA_W - KEEP_BITS;

  logic [DATA_W-1:0] keep_mask;
  logic [DATA_W-1:0] merged;
  logic [DATA_W-1:0] word_d;

  // Mask of held bits; the variant without dropped bits needs no zero field.
  generate
    if (DROP_BITS == 0) begin : g_full
      assign keep_mask = '1;
    end else begin : g_part
      assign keep_mask = {{KEEP_BITS{1'b1}}, {DROP_BITS{1'b0}}};
    end
  endgenerate

  always_comb begin
    unique case (slot)
      SLOT_DIRECT: merged = wdata;
      SLOT_AND:    merged = word_q & wdata;
      SLOT_OR:     merged = word_q | wdata;
      default:     merged = word_q;
    endcase
  end

  assign word_d = merged & keep_mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
    end else if (wr_en && (slot != SLOT_NONE)) begin
      word_q <= word_d;
    end
  end

  assign irq = word_q[DATA_W-1];
endmodule

// File: rtl/ar_resp.sv
module ar_resp
  import alias_reg_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_we,
  input  logic              legal,
  input  slot_e             slot,
  input  logic [DATA_W-1:0] word_q,
  output logic              resp_valid,
  output logic [DATA_W-1:0] resp_rdata,
  output logic              resp_err,
  output logic              resp_unimpl
);
  logic              rd_hit;
  logic              unimpl_d;
  logic [DATA_W-1:0] rdata_d;

  assign rd_hit   = req_valid && !req_we && legal && (slot == SLOT_DIRECT);
  assign unimpl_d = req_valid && legal &&
                    (req_we ? (slot == SLOT_NONE) : (slot != SLOT_DIRECT));
  assign rdata_d  = rd_hit ? word_q : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resp_valid  <= 1'b0;
      resp_rdata  <= '0;
      resp_err    <= 1'b0;
      resp_unimpl <= 1'b0;
    end else begin
      resp_valid  <= req_valid;
      resp_rdata  <= rdata_d;
      resp_err    <= req_valid && !legal;
      resp_unimpl <= unimpl_d;
    end
  end
endmodule

// File: rtl/alias_ctl_reg.sv
module alias_ctl_reg
  import alias_reg_pkg::*;
#(
  parameter int ADDR_W       = 24,
  parameter int SIZE_W       = 4,
  parameter int KEEP_BITS    = 16,
  parameter int BASE_INDEX   = 'h4020
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [SIZE_W-1:0] req_size,
  input  logic [63:0]       req_wdata,
  output logic              resp_valid,
  output logic [63:0]       resp_rdata,
  output logic              resp_err,
  output logic              resp_unimpl,
  output logic              irq_out
);
  localparam int DATA_W       = 64;
  localparam int ACCESS_BYTES = DATA_W / 8;

  logic              legal;
  slot_e             slot;
  logic [DATA_W-1:0] word_q;
  logic              wr_en;

  assign wr_en = req_valid && req_we && legal;

  ar_decode #(
    .ADDR_W      (ADDR_W),
    .SIZE_W      (SIZE_W),
    .ACCESS_BYTES(ACCESS_BYTES),
    .BASE_INDEX  (BASE_INDEX)
  ) u_decode (
    .addr (req_addr),
    .size (req_size),
    .legal(legal),
    .slot (slot)
  );

  ar_store #(
    .DATA_W   (DATA_W),
    .KEEP_BITS(KEEP_BITS)
  ) u_store (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (wr_en),
    .slot  (slot),
    .wdata (req_wdata),
    .word_q(word_q),
    .irq   (irq_out)
  );

  ar_resp #(
    .DATA_W(DATA_W)
  ) u_resp (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_we     (req_we),
    .legal      (legal),
    .slot       (slot),
    .word_q     (word_q),
    .resp_valid (resp_valid),
    .resp_rdata (resp_rdata),
    .resp_err   (resp_err),
    .resp_unimpl(resp_unimpl)
  );
endmodule

// File: rtl/alias_ctl_reg_chk.sv
module alias_ctl_reg_chk #(
  parameter int ADDR_W     = 24,
  parameter int SIZE_W     = 4,
  parameter int KEEP_BITS  = 16,
  parameter int BASE_INDEX = 'h4020
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_we,
  input logic [ADDR_W-1:0] req_addr,
  input logic [SIZE_W-1:0] req_size,
  input logic [63:0]       resp_rdata,
  input logic              resp_valid,
  input logic              resp_err,
  input logic              resp_unimpl,
  input logic              irq_out
);
  localparam logic [63:0] LOW_MASK = ~({64{1'b1}} << (64 - KEEP_BITS));
  localparam int IDX_W = ADDR_W - 3;

  logic bad_req;
  logic stray_wr;
  assign bad_req  = req_valid && ((req_size != SIZE_W'(8)) || (req_addr[2:0] != 3'd0));
  assign stray_wr = req_valid && req_we && !bad_req &&
                    (req_addr[ADDR_W-1:3] != IDX_W'(BASE_INDEX)) &&
                    (req_addr[ADDR_W-1:3] != IDX_W'(BASE_INDEX + 1)) &&
                    (req_addr[ADDR_W-1:3] != IDX_W'(BASE_INDEX + 2));

  a_r10_resp_follows: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> resp_valid);
  a_r10_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !resp_valid);
  a_r7_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({resp_err, resp_unimpl}));
  a_r7_flags_in_resp: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_err || resp_unimpl) |-> resp_valid);
  a_r4_low_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_rdata & LOW_MASK) == 64'd0);
  a_r8_err_no_data: assert property (@(posedge clk) disable iff (!rst_n)
    resp_err |-> (resp_rdata == 64'd0));
  a_r8_bad_keeps_irq: assert property (@(posedge clk) disable iff (!rst_n)
    bad_req |=> $stable(irq_out));
  a_r7_stray_keeps_irq: assert property (@(posedge clk) disable iff (!rst_n)
    stray_wr |=> $stable(irq_out));
  a_r5_read_matches_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && !resp_err && !resp_unimpl && !$past(req_we)) |-> (resp_rdata[63] == irq_out));
endmodule

bind alias_ctl_reg alias_ctl_reg_chk #(
  .ADDR_W    (ADDR_W),
  .SIZE_W    (SIZE_W),
  .KEEP_BITS (KEEP_BITS),
  .BASE_INDEX(BASE_INDEX)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_we     (req_we),
  .req_addr   (req_addr),
  .req_size   (req_size),
  .resp_rdata (resp_rdata),
  .resp_valid (resp_valid),
  .resp_err   (resp_err),
  .resp_unimpl(resp_unimpl),
  .irq_out    (irq_out)
);

// File: tb/test_alias_ctl_reg.sv
module test_alias_ctl_reg;
  localparam int ADDR_W = 24;
  localparam int SIZE_W = 4;
  localparam int KEEP   = 16;
  localparam int BASE   = 'h4020;
  localparam logic [63:0] MASK = {{KEEP{1'b1}}, {(64-KEEP){1'b0}}};

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req_valid = 1'b0;
  logic              req_we = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [SIZE_W-1:0] req_size = '0;
  logic [63:0]       req_wdata = '0;
  logic              resp_valid;
  logic [63:0]       resp_rdata;
  logic              resp_err;
  logic              resp_unimpl;
  logic              irq_out;

  int checks = 0;
  int errors = 0;
  logic [63:0] model = '0;

  always #5 clk = ~clk;

  alias_ctl_reg #(
    .ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .KEEP_BITS(KEEP), .BASE_INDEX(BASE)
  ) i_alias_ctl_reg (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_we(req_we),
    .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
    .resp_valid(resp_valid), .resp_rdata(resp_rdata), .resp_err(resp_err),
    .resp_unimpl(resp_unimpl), .irq_out(irq_out)
  );

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [ADDR_W-1:0] slot_addr(int idx);
    return ADDR_W'(idx) << 3;
  endfunction

  // One isolated request; the response is checked one cycle later.
  task automatic access(bit we, logic [ADDR_W-1:0] addr, logic [SIZE_W-1:0] size,
                        logic [63:0] wd);
    bit ok;
    int idx;
    logic [63:0] e_rd;
    bit e_err, e_un;
    string tag;
    ok = (size == 4'd8) && (addr[2:0] == 3'd0);
    idx = int'(addr >> 3);
    e_rd = '0; e_err = 1'b0; e_un = 1'b0;
    if (!ok) begin
      e_err = 1'b1; tag = "R8";
    end else if (we) begin
      if (idx == BASE)          begin model = wd & MASK;           tag = "R1"; end
      else if (idx == BASE + 1) begin model = model & wd & MASK;   tag = "R2"; end
      else if (idx == BASE + 2) begin model = (model | wd) & MASK; tag = "R3"; end
      else                      begin e_un = 1'b1;                 tag = "R7"; end
    end else begin
      if (idx == BASE) begin e_rd = model; tag = "R6"; end
      else begin e_un = 1'b1; tag = "R7"; end
    end
    @(negedge clk);
    req_valid = 1'b1; req_we = we; req_addr = addr; req_size = size; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0; req_we = 1'b0;
    chk({"R10 resp_valid ", tag}, 64'(resp_valid), 64'd1);
    chk({tag, " rdata"}, resp_rdata, e_rd);
    chk({tag, " err R8"}, 64'(resp_err), 64'(e_err));
    chk({tag, " unimpl R7"}, 64'(resp_unimpl), 64'(e_un));
    chk({tag, " irq R5"}, 64'(irq_out), 64'(model[63]));
  endtask

  task automatic read_direct_check(string tag);
    access(1'b0, slot_addr(BASE), 4'd8, 64'd0);
    chk({tag, " low bits R4"}, resp_rdata & ~MASK, 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R9 resp_valid in reset", 64'(resp_valid), 64'd0);
    chk("R9 irq in reset", 64'(irq_out), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9 resp_valid idle", 64'(resp_valid), 64'd0);
    read_direct_check("R9 reset value");

    // Direct writes with varied patterns, read back each.
    for (int k = 0; k < 8; k++) begin
      logic [63:0] p;
      p = 64'(k + 1) * 64'h9E37_79B9_7F4A_7C15;
      access(1'b1, slot_addr(BASE), 4'd8, p);
      read_direct_check("R1 pattern");
    end
    access(1'b1, slot_addr(BASE), 4'd8, '1);
    read_direct_check("R4 all ones");

    // Per-bit set via OR alias then clear via AND alias.
    access(1'b1, slot_addr(BASE), 4'd8, 64'd0);
    for (int b = 0; b < 64; b++) begin
      access(1'b1, slot_addr(BASE + 2), 4'd8, 64'd1 << b);
      read_direct_check("R3 set bit");
    end
    for (int b = 63; b >= 0; b--) begin
      access(1'b1, slot_addr(BASE + 1), 4'd8, ~(64'd1 << b));
      read_direct_check("R2 clear bit");
    end

    // Index sweep around the slots, reads and writes.
    access(1'b1, slot_addr(BASE), 4'd8, 64'hA5C3_0000_0000_0000);
    for (int i = BASE - 4; i <= BASE + 6; i++) begin
      access(1'b0, slot_addr(i), 4'd8, 64'd0);
      if (i < BASE || i > BASE + 2) begin
        access(1'b1, slot_addr(i), 4'd8, 64'h0000_0000_0000_0000);
        read_direct_check("R7 stray write");
      end
    end

    // Illegal sizes and misalignment.
    for (int s = 0; s < 16; s++) begin
      if (s != 8) begin
        access(1'b1, slot_addr(BASE), 4'(s), 64'd0);
        access(1'b0, slot_addr(BASE), 4'(s), 64'd0);
      end
    end
    for (int a = 1; a < 8; a++) begin
      access(1'b1, slot_addr(BASE) + ADDR_W'(a), 4'd8, 64'd0);
      access(1'b1, slot_addr(BASE + 1) + ADDR_W'(a), 4'd8, 64'd0);
    end
    read_direct_check("R8 after illegal");

    // Back-to-back: write direct then read direct on consecutive cycles.
    @(negedge clk);
    req_valid = 1'b1; req_we = 1'b1; req_addr = slot_addr(BASE); req_size = 4'd8;
    req_wdata = 64'h1234_5678_9ABC_DEF0;
    model = req_wdata & MASK;
    @(negedge clk);
    chk("R10 b2b first resp", 64'(resp_valid), 64'd1);
    chk("R5 b2b irq", 64'(irq_out), 64'(model[63]));
    req_we = 1'b0; req_wdata = '0;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R10 b2b second resp", 64'(resp_valid), 64'd1);
    chk("R10 b2b read data", resp_rdata, model);
    @(negedge clk);
    chk("R10 idle after b2b", 64'(resp_valid), 64'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R10 watchdog actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule